// File: doc/BRIEF.md
# Retired Instruction Event Counter

This block sits beside a processor core and watches the per-instruction trace strobes that the core emits as each instruction retires. The block only counts. For every retired instruction it works out the events that belong to it and adds one to a saturating counter for each of them. The events are: the retirement itself, a taken jump, a branch-target-cache hit, a branch-target-cache mispredict, and one class of exception cause. A sparse 6-bit cause code is sorted into four classes: synchronous fault, interrupt, environment call and reserved code.

Each privilege level has its own bank of event counters. The level is taken from the privilege field at the moment the instruction retires. When the privilege field carries its undefined value, the instruction goes to a separate error counter and to no bank. A combinational read port selects any counter by a 5-bit address. A synchronous clear pulse zeroes every counter. While the debug-halted flag is high, nothing advances.

Top module: `rtev_counter`

## Requirements
- R1: When `instr_valid` is low in a cycle, no counter changes in that cycle, whatever the other trace inputs carry.
- R2: `exc_kind` is used only when `exc_taken` is high. A valid instruction with `exc_taken` low increments none of the four cause counters.
- R3: Cause codes 0x20, 0x2B and 0x30 increment the interrupt counter (event 5).
- R4: Cause codes 0x08, 0x09 and 0x0B increment the environment-call counter (event 6). Code 0x0A is not an environment call.
- R5: Cause codes 0x00 to 0x07, 0x0C, 0x0D, 0x0F and 0x18 increment the synchronous-fault counter (event 4).
- R6: Every other cause code increments the reserved-code counter (event 7). Each taken exception increments exactly one cause counter.
- R7: Each valid instruction increments the retired counter (event 0) in the bank of its privilege level: 00 user, 01 supervisor, 11 machine. The read address is {privilege[1:0], event[2:0]}, so the user bank sits at 0–7, the supervisor bank at 8–15 and the machine bank at 24–31.
- R8: A valid instruction with privilege 10 increments the error counter and no bank counter. Addresses 16–23 all read the error counter.
- R9: A taken jump increments event 1. When `BTC_EN` is 1 and the jump is taken, the hit flag increments event 2 and the mispredict flag increments event 3. The hit and mispredict flags are ignored on instructions without a taken jump.
- R10: While `halted` is high, no counter changes, including the error counter.
- R11: Each counter holds at all-ones once it reaches all-ones.
- R12: A high `clr` at a clock edge zeroes every counter at that edge. If an increment falls in the same cycle, the clear takes priority.
- R13: After reset, every address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| instr_valid | input | 1 | A retired instruction is present this cycle |
| exc_taken | input | 1 | The instruction took an exception |
| exc_kind | input | 6 | Exception cause code |
| jmp_taken | input | 1 | Jump or branch taken |
| btc_hit | input | 1 | Branch-target-cache hit |
| btc_miss | input | 1 | Branch-target-cache mispredict |
| priv | input | 2 | Privilege level of the instruction |
| halted | input | 1 | Pipeline halted by debug |
| rd_addr | input | 5 | Counter select {privilege, event} |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The clear pulse and a counted instruction can land in the same cycle. The bench raises `clr` on the same edge as a valid instruction that carries a taken jump and an exception, then reads every address and expects zero, because the clear wins. A second collision is a valid instruction issued while `halted` is high. This is judged the same way: the full counter image must not change. Both cases are checked against a bench model. The model sorts cause codes with its own range tests, so it shares no code with the design's decode.

// File: rtl/rtev_pkg.sv
package rtev_pkg;

  localparam int NUM_EVT = 8;
  localparam int EVT_W   = $clog2(NUM_EVT);
  localparam int PRIV_W  = 2;
  localparam int ADDR_W  = PRIV_W + EVT_W;
  localparam int NUM_SLOT = 1 << ADDR_W;

  // event index within one privilege bank
  localparam int EV_RETIRE = 0;
  localparam int EV_JUMP   = 1;
  localparam int EV_HIT    = 2;
  localparam int EV_MISS   = 3;
  localparam int EV_FAULT  = 4;
  localparam int EV_INTR   = 5;
  localparam int EV_ECALL  = 6;
  localparam int EV_RSVD   = 7;

  localparam logic [PRIV_W-1:0] PRIV_BAD = 2'b10;

  typedef enum logic [1:0] {
    CL_FAULT,
    CL_INTR,
    CL_ECALL,
    CL_RSVD
  } cause_cls_e;

  // sort a sparse cause code into its class
  function automatic cause_cls_e classify_cause(input logic [5:0] code);
    cause_cls_e cls;
    case (code)
      6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
      6'h0C, 6'h0D, 6'h0F, 6'h18: cls = CL_FAULT;
      6'h08, 6'h09, 6'h0B:        cls = CL_ECALL;
      6'h20, 6'h2B, 6'h30:        cls = CL_INTR;
      default:                    cls = CL_RSVD;
    endcase
    return cls;
  endfunction

  function automatic logic priv_defined(input logic [PRIV_W-1:0] p);
    return p != PRIV_BAD;
  endfunction

endpackage

// File: rtl/rtev_decode.sv
module rtev_decode
  import rtev_pkg::*;
#(
  parameter bit BTC_EN = 1'b1
) (
  input  logic                 instr_valid,
  input  logic                 exc_taken,
  input  logic [5:0]           exc_kind,
  input  logic                 jmp_taken,
  input  logic                 btc_hit,
  input  logic                 btc_miss,
  input  logic [PRIV_W-1:0]    priv,
  input  logic                 halted,
  output logic [NUM_EVT-1:0]   evt_hit,
  output logic                 err_hit
);

  logic       live;
  logic       bank_ok;
  cause_cls_e cls;

  assign live    = instr_valid && !halted;
  assign bank_ok = live && priv_defined(priv);
  assign err_hit = live && !priv_defined(priv);
  assign cls     = classify_cause(exc_kind);

  always_comb begin
    evt_hit            = '0;
    evt_hit[EV_RETIRE] = bank_ok;
    evt_hit[EV_JUMP]   = bank_ok && jmp_taken;
    evt_hit[EV_HIT]    = bank_ok && jmp_taken && btc_hit  && BTC_EN;
    evt_hit[EV_MISS]   = bank_ok && jmp_taken && btc_miss && BTC_EN;
    evt_hit[EV_FAULT]  = bank_ok && exc_taken && (cls == CL_FAULT);
    evt_hit[EV_INTR]   = bank_ok && exc_taken && (cls == CL_INTR);
    evt_hit[EV_ECALL]  = bank_ok && exc_taken && (cls == CL_ECALL);
    evt_hit[EV_RSVD]   = bank_ok && exc_taken && (cls == CL_RSVD);
  end

endmodule

// File: rtl/rtev_sat_cnt.sv
module rtev_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != TOP)   q <= q + 1'b1;
  end

endmodule

// File: rtl/rtev_counter.sv
module rtev_counter
  import rtev_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter bit BTC_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 instr_valid,
  input  logic                 exc_taken,
  input  logic [5:0]           exc_kind,
  input  logic                 jmp_taken,
  input  logic                 btc_hit,
  input  logic                 btc_miss,
  input  logic [1:0]           priv,
  input  logic                 halted,
  input  logic [4:0]           rd_addr,
  output logic [CNT_W-1:0]     rd_data
);

  localparam int NUM_BANK = 1 << PRIV_W;

  logic [NUM_EVT-1:0] evt_hit;
  logic               err_hit;
  logic [CNT_W-1:0]   slot_q [NUM_SLOT];
  logic [CNT_W-1:0]   err_q;

  rtev_decode #(.BTC_EN(BTC_EN)) u_dec (
    .instr_valid (instr_valid),
    .exc_taken   (exc_taken),
    .exc_kind    (exc_kind),
    .jmp_taken   (jmp_taken),
    .btc_hit     (btc_hit),
    .btc_miss    (btc_miss),
    .priv        (priv),
    .halted      (halted),
    .evt_hit     (evt_hit),
    .err_hit     (err_hit)
  );

  for (genvar p = 0; p < NUM_BANK; p++) begin : g_bank
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      if (p == int'(PRIV_BAD)) begin : g_hole
        assign slot_q[p*NUM_EVT+e] = '0;
      end else begin : g_cnt
        logic inc;
        assign inc = evt_hit[e] && (priv == PRIV_W'(p));
        rtev_sat_cnt #(.W(CNT_W)) u_cnt (
          .clk   (clk),
          .rst_n (rst_n),
          .clr   (clr),
          .inc   (inc),
          .q     (slot_q[p*NUM_EVT+e])
        );
      end
    end
  end

  rtev_sat_cnt #(.W(CNT_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (err_hit),
    .q     (err_q)
  );

  assign rd_data = (rd_addr[ADDR_W-1:EVT_W] == PRIV_BAD) ? err_q : slot_q[rd_addr];

endmodule

// File: rtl/rtev_checker.sv
module rtev_checker
  import rtev_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               instr_valid,
  input logic               exc_taken,
  input logic               jmp_taken,
  input logic               halted,
  input logic [NUM_EVT-1:0] evt_hit,
  input logic               err_hit,
  input logic [4:0]         rd_addr,
  input logic [CNT_W-1:0]   rd_data
);

  // R1: nothing fires without a valid instruction
  a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (evt_hit == '0 && !err_hit));

  // R2: cause classes need exc_taken
  a_r2_cause_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> (evt_hit[EV_RSVD:EV_FAULT] == '0));

  // R6: at most one cause class per instruction
  a_r6_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_hit[EV_RSVD:EV_FAULT]));

  // R8: undefined privilege goes nowhere but the error counter
  a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |-> (evt_hit == '0));

  // R9: cache events only accompany a taken jump
  a_r9_btc_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit[EV_HIT] || evt_hit[EV_MISS]) |-> (jmp_taken && evt_hit[EV_JUMP]));

  // R10: debug halt freezes everything
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (evt_hit == '0 && !err_hit));

  // R11: a full counter stays full
  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '1 && !clr) |=> (rd_data == '1 || !$stable(rd_addr)));

  // R12: clear empties the selected counter on the next cycle
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_data == '0));

endmodule

bind rtev_counter rtev_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .instr_valid (instr_valid),
  .exc_taken   (exc_taken),
  .jmp_taken   (jmp_taken),
  .halted      (halted),
  .evt_hit     (evt_hit),
  .err_hit     (err_hit),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data)
);

// File: tb/rtev_counter_test.sv
`timescale 1ns/1ps
module rtev_counter_test;

  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         instr_valid = 1'b0;
  logic         exc_taken = 1'b0;
  logic [5:0]   exc_kind = '0;
  logic         jmp_taken = 1'b0;
  logic         btc_hit = 1'b0;
  logic         btc_miss = 1'b0;
  logic [1:0]   priv = '0;
  logic         halted = 1'b0;
  logic [4:0]   rd_addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int model [32];
  int err_model = 0;

  always #2 clk = ~clk;

  rtev_counter #(.CNT_W(W), .BTC_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .instr_valid(instr_valid),
    .exc_taken(exc_taken), .exc_kind(exc_kind), .jmp_taken(jmp_taken),
    .btc_hit(btc_hit), .btc_miss(btc_miss), .priv(priv), .halted(halted),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int bump(input int v);
    return (v >= MAX) ? MAX : v + 1;
  endfunction

  // cause class slot by range tests: 4 fault, 5 interrupt, 6 ecall, 7 reserved
  function automatic int cause_slot(input int k);
    if (k < 8 || k == 12 || k == 13 || k == 15 || k == 24) return 4;
    if (k == 8 || k == 9 || k == 11) return 6;
    if (k == 32 || k == 43 || k == 48) return 5;
    return 7;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = 0;
    err_model = 0;
  endtask

  task automatic step(input bit v, input bit e, input int k, input bit j,
                      input bit h, input bit m, input int p, input bit hl,
                      input bit c);
    instr_valid = v; exc_taken = e; exc_kind = 6'(k); jmp_taken = j;
    btc_hit = h; btc_miss = m; priv = 2'(p); halted = hl; clr = c;
    @(posedge clk);
    #1;
    instr_valid = 0; exc_taken = 0; exc_kind = '0; jmp_taken = 0;
    btc_hit = 0; btc_miss = 0; priv = '0; halted = 0; clr = 0;
    if (c) clear_model();
    else if (v && !hl) begin
      if (p == 2) err_model = bump(err_model);
      else begin
        model[p*8] = bump(model[p*8]);
        if (j) model[p*8+1] = bump(model[p*8+1]);
        if (j && h) model[p*8+2] = bump(model[p*8+2]);
        if (j && m) model[p*8+3] = bump(model[p*8+3]);
        if (e) model[p*8+cause_slot(k)] = bump(model[p*8+cause_slot(k)]);
      end
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 32; a++) begin
      int exp_v;
      exp_v = (a / 8 == 2) ? err_model : model[a];
      rd_addr = 5'(a);
      #0.5;
      checks++;
      if (int'(rd_data) != exp_v) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, rd_data, exp_v);
      end
    end
  endtask

  task automatic t_reset();     // R13
    check_all("R13 reset");
  endtask

  task automatic t_gating();    // R1
    step(0, 1, 2, 1, 1, 1, 0, 0, 0);
    step(0, 1, 32, 1, 0, 0, 3, 0, 0);
    step(0, 0, 0, 0, 0, 0, 2, 0, 0);
    check_all("R1 no valid");
  endtask

  task automatic t_noexc();     // R2
    step(1, 0, 8, 0, 0, 0, 3, 0, 0);
    step(1, 0, 63, 0, 0, 0, 1, 0, 0);
    check_all("R2 kind ignored");
  endtask

  task automatic t_classes();   // R3 R4 R5 R6
    for (int k = 0; k < 64; k++) step(1, 1, k, 0, 0, 0, 3, 0, 0);
    check_all("R3_R4_R5_R6 cause sweep");
    step(1, 1, 10, 0, 0, 0, 0, 0, 0);
    check_all("R4 code 0A reserved");
  endtask

  task automatic t_priv();      // R7 R8
    step(1, 1, 9, 1, 0, 0, 0, 0, 0);
    step(1, 1, 43, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 1, 0, 3, 0, 0);
    step(1, 1, 5, 1, 1, 1, 2, 0, 0);
    step(1, 0, 0, 0, 0, 0, 2, 0, 0);
    check_all("R7_R8 privilege banks");
  endtask

  task automatic t_btc();       // R9
    step(1, 0, 0, 1, 1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 1, 1, 0, 0);
    step(1, 0, 0, 0, 1, 1, 1, 0, 0);
    step(1, 0, 0, 1, 1, 1, 0, 0, 0);
    check_all("R9 branch cache");
  endtask

  task automatic t_halt();      // R10
    step(1, 1, 48, 1, 1, 1, 3, 1, 0);
    step(1, 0, 0, 0, 0, 0, 2, 1, 0);
    check_all("R10 halted");
  endtask

  task automatic t_sat();       // R11
    for (int i = 0; i < MAX + 6; i++) step(1, 0, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < MAX + 3; i++) step(1, 0, 0, 0, 0, 0, 2, 0, 0);
    check_all("R11 saturate");
  endtask

  task automatic t_clear();     // R12
    step(1, 1, 3, 1, 1, 0, 3, 0, 1);
    check_all("R12 clear wins");
    step(1, 1, 11, 0, 0, 0, 3, 0, 0);
    check_all("R12 counts after clear");
  endtask

  initial begin
    clear_model();
    #9 rst_n = 1'b1;
    #3;
    t_reset();
    t_gating();
    t_noexc();
    t_classes();
    t_priv();
    t_btc();
    t_halt();
    t_sat();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule